// File: doc/BRIEF.md
# Indirect Jump Return Predictor

This block predicts the target of an indirect jump when the jump is fetched. It keeps a small stack of return addresses in a circular buffer. Each jump presents a kind code, the address of the instruction after it (its return address) and a 16-bit static hint. A call pushes its return address. A return pops the most recent address and predicts a jump there. A coroutine jump exchanges the top entry for its own return address and predicts the entry it displaced. A plain jump leaves the stack alone. Plain jumps and calls do not use the stack for their prediction. Their target is formed from the upper bits of the presented return address with the hint as the low 16 bits.

Every accepted request gets a registered answer on the next clock edge. The answer is a done strobe, a prediction-valid bit and the predicted address. A return or coroutine jump that finds the stack empty answers with the valid bit low. When the stack is full, a push overwrites the oldest entry. Recovery of the stack after a misprediction is not handled here.

Top module: `ras_top`

## Requirements
- R1: After synchronous reset, pred_done, pred_valid and pred_target are all zero and the stack is empty.
- R2: Each cycle with req_valid high produces exactly one cycle of pred_done high on the next cycle. Cycles with req_valid low produce no pred_done.
- R3: Kind code 2'b00 (plain jump) predicts valid with target {req_ret_addr[ADDR_W-1:16], req_hint} and leaves the stack contents and depth unchanged.
- R4: Kind code 2'b01 (call) predicts valid with the same hint-formed target as R3, and pushes req_ret_addr onto the stack.
- R5: Kind code 2'b10 (return) on a non-empty stack predicts valid with the top entry as target, and removes that entry.
- R6: A return on an empty stack answers with pred_valid low and pred_target zero, and the stack stays empty.
- R7: Kind code 2'b11 (coroutine) on a non-empty stack predicts valid with the old top entry, and replaces that entry with req_ret_addr without changing the depth.
- R8: A coroutine jump on an empty stack answers with pred_valid low and pred_target zero, and pushes req_ret_addr.
- R9: A push onto a stack holding DEPTH entries overwrites the oldest entry. The depth stays DEPTH, and later returns give the newest DEPTH addresses, newest first.
- R10: The hint is ignored for returns and coroutine jumps, and idle cycles leave the stack unchanged.
- R11: When no answer is being given, pred_valid and pred_target are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A jump is presented this cycle |
| req_kind | input | 2 | 00 plain jump, 01 call, 10 return, 11 coroutine |
| req_ret_addr | input | ADDR_W | Address of the instruction after the jump |
| req_hint | input | HINT_W | Static low-bits target hint |
| pred_done | output | 1 | Answer strobe, one cycle after a request |
| pred_valid | output | 1 | Prediction is usable |
| pred_target | output | ADDR_W | Predicted jump target |

## Verification
A coroutine jump reads the top entry and writes a new value into the same slot in one cycle. This is provoked with back-to-back coroutine jumps, each predicting the address the previous one stored. A push onto a full stack also advances the top pointer into the slot of the oldest entry as it writes. This is provoked by ten calls into eight slots, and judged by draining with returns, which must yield the newest eight addresses and then an invalid answer. A scoreboard stack in the bench gives the expected answer for each request.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        JK_JUMP = 2'b00,
        JK_CALL = 2'b01,
        JK_RET  = 2'b10,
        JK_CORO = 2'b11
    } jump_kind_e;

    typedef struct packed {
        logic push;      // write new address above top
        logic pop;       // drop top
        logic swap;      // overwrite top in place
        logic use_hint;  // prediction from hint
        logic from_top;  // prediction from top entry
    } stack_op_t;

    function automatic stack_op_t decode_kind(input logic fire,
                                              input jump_kind_e kind,
                                              input logic empty);
        stack_op_t op;
        op = '0;
        if (fire) begin
            case (kind)
                JK_JUMP: op.use_hint = 1'b1;
                JK_CALL: begin
                    op.use_hint = 1'b1;
                    op.push     = 1'b1;
                end
                JK_RET: begin
                    op.pop      = !empty;
                    op.from_top = !empty;
                end
                JK_CORO: begin
                    op.push     = empty;
                    op.swap     = !empty;
                    op.from_top = !empty;
                end
                default: op = '0;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  stack_op_t        op,
    output logic [IDX_W-1:0] top_idx,
    output logic [CNT_W-1:0] occ,
    output logic             empty,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [IDX_W-1:0] idx_up;
    logic [IDX_W-1:0] idx_down;

    always_comb begin
        idx_up   = (top_idx == LAST_IDX) ? '0 : top_idx + 1'b1;
        idx_down = (top_idx == '0) ? LAST_IDX : top_idx - 1'b1;
    end

    assign empty  = (occ == '0);
    assign wr_en  = op.push | op.swap;
    assign wr_idx = op.push ? idx_up : top_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_idx <= LAST_IDX;
            occ     <= '0;
        end else if (op.push) begin
            top_idx <= idx_up;
            if (occ != FULL_CNT) begin
                occ <= occ + 1'b1;
            end
        end else if (op.pop) begin
            top_idx <= idx_down;
            occ     <= occ - 1'b1;
        end
    end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/ras_predict.sv
module ras_predict #(
    parameter int ADDR_W = 64,
    parameter int HINT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fire,
    input  logic                     use_hint,
    input  logic                     from_top,
    input  logic [ADDR_W-HINT_W-1:0] ret_upper,
    input  logic [HINT_W-1:0]        hint,
    input  logic [ADDR_W-1:0]        top_data,
    output logic                     pred_done,
    output logic                     pred_valid,
    output logic [ADDR_W-1:0]        pred_target
);

    logic [ADDR_W-1:0] target_d;

    always_comb begin
        if (use_hint) begin
            target_d = {ret_upper, hint};
        end else if (from_top) begin
            target_d = top_data;
        end else begin
            target_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_done   <= 1'b0;
            pred_valid  <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_done   <= fire;
            pred_valid  <= use_hint | from_top;
            pred_target <= target_d;
        end
    end

endmodule

// File: rtl/ras_top.sv
module ras_top
    import ras_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 64,
    parameter int HINT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_ret_addr,
    input  logic [HINT_W-1:0] req_hint,
    output logic              pred_done,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_target
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    stack_op_t         op;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  occ;
    logic              empty;
    logic              wr_en;
    logic [ADDR_W-1:0] top_data;

    assign op = decode_kind(req_valid, jump_kind_e'(req_kind), empty);

    ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .top_idx (top_idx),
        .occ     (occ),
        .empty   (empty),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx)
    );

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (req_ret_addr),
        .rd_idx  (top_idx),
        .rd_data (top_data)
    );

    ras_predict #(.ADDR_W(ADDR_W), .HINT_W(HINT_W)) u_pred (
        .clk         (clk),
        .rst         (rst),
        .fire        (req_valid),
        .use_hint    (op.use_hint),
        .from_top    (op.from_top),
        .ret_upper   (req_ret_addr[ADDR_W-1:HINT_W]),
        .hint        (req_hint),
        .top_data    (top_data),
        .pred_done   (pred_done),
        .pred_valid  (pred_valid),
        .pred_target (pred_target)
    );

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 64,
    parameter int HINT_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_ret_addr,
    input logic [HINT_W-1:0] req_hint,
    input logic              pred_done,
    input logic              pred_valid,
    input logic [ADDR_W-1:0] pred_target,
    input logic [CNT_W-1:0]  occ
);

    assert_answer_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid) |=> pred_done);

    assert_no_spurious_answer_R2: assert property (@(posedge clk) disable iff (rst)
        (!req_valid) |=> !pred_done);

    assert_hint_target_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b00) |=>
        (pred_valid && pred_target == {$past(req_ret_addr[ADDR_W-1:HINT_W]), $past(req_hint)}
         && occ == $past(occ)));

    assert_call_grows_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b01) |=>
        (occ == (($past(occ) == CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : $past(occ) + 1'b1)));

    assert_empty_ret_invalid_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b10 && occ == '0) |=> (!pred_valid && occ == '0));

    assert_swap_keeps_depth_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b11 && occ != '0) |=> (pred_valid && occ == $past(occ)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    assert_idle_outputs_R11: assert property (@(posedge clk) disable iff (rst)
        (!pred_done) |-> (!pred_valid && pred_target == '0));

endmodule

bind ras_top ras_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .HINT_W(HINT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_ret_addr (req_ret_addr),
    .req_hint     (req_hint),
    .pred_done    (pred_done),
    .pred_valid   (pred_valid),
    .pred_target  (pred_target),
    .occ          (occ)
);

// File: tb/ras_top_test.sv
module ras_top_test;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 64;
    localparam int HINT_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = 2'b00;
    logic [ADDR_W-1:0] req_ret_addr = '0;
    logic [HINT_W-1:0] req_hint = '0;
    logic              pred_done;
    logic              pred_valid;
    logic [ADDR_W-1:0] pred_target;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic              v;
        logic [ADDR_W-1:0] t;
        string             req;
    } exp_t;

    exp_t              expq[$];
    logic [ADDR_W-1:0] model[$];

    always #4 clk = ~clk;

    ras_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .HINT_W(HINT_W)) uut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .req_ret_addr (req_ret_addr),
        .req_hint     (req_hint),
        .pred_done    (pred_done),
        .pred_valid   (pred_valid),
        .pred_target  (pred_target)
    );

    task automatic check(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: computes the expected answer from the bench's own stack model
    task automatic issue(input logic [1:0] kind, input logic [ADDR_W-1:0] ra,
                         input logic [HINT_W-1:0] hint, input string req);
        exp_t e;
        e.req = req;
        e.v = 1'b0;
        e.t = '0;
        case (kind)
            2'b00: begin e.v = 1'b1; e.t = {ra[ADDR_W-1:HINT_W], hint}; end
            2'b01: begin
                e.v = 1'b1; e.t = {ra[ADDR_W-1:HINT_W], hint};
                model.push_back(ra);
                if (model.size() > DEPTH) void'(model.pop_front());
            end
            2'b10: if (model.size() > 0) begin e.v = 1'b1; e.t = model.pop_back(); end
            default: begin
                if (model.size() > 0) begin
                    e.v = 1'b1; e.t = model.pop_back();
                end
                model.push_back(ra);
            end
        endcase
        expq.push_back(e);
        req_valid = 1'b1;
        req_kind = kind;
        req_ret_addr = ra;
        req_hint = hint;
        @(negedge clk);
        req_valid = 1'b0;
        req_hint = 16'hFFFF;
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        check(pred_done == 1'b0, req, {63'd0, pred_done}, '0);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && pred_done) begin
            if (expq.size() == 0) begin
                check(1'b0, "R2 unexpected answer", '0, '0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(pred_valid == e.v, {e.req, " valid"}, {63'd0, pred_valid}, {63'd0, e.v});
                check(pred_target == e.t, {e.req, " target"}, pred_target, e.t);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(pred_done == 1'b0 && pred_valid == 1'b0 && pred_target == '0,
              "R1 reset outputs", pred_target, '0);
        issue(2'b10, 64'h0, 16'h0, "R1 R6 empty after reset");
        issue(2'b00, 64'h1234_5678_9ABC_DEF0, 16'h4321, "R3 jump hint");
        issue(2'b01, 64'hAAAA_0000_0000_1000, 16'h00F0, "R4 call A1");
        issue(2'b01, 64'hAAAA_0000_0000_2000, 16'h0F00, "R4 call A2");
        issue(2'b00, 64'hBEEF_0000_0000_0004, 16'h1111, "R3 jump mid stack");
        issue(2'b10, 64'h5555_0000_0000_0000, 16'h7777, "R5 R10 ret A2");
        idle_chk("R2 R10 idle");
        idle_chk("R2 R10 idle");
        issue(2'b10, 64'h0, 16'h0, "R5 ret A1");
        issue(2'b10, 64'h0, 16'h0, "R6 ret empty");
        issue(2'b10, 64'h0, 16'h0, "R6 still empty");
        issue(2'b11, 64'hC000_0000_0000_0010, 16'hABCD, "R8 coro empty");
        issue(2'b10, 64'h0, 16'h0, "R8 pushed by coro");
        issue(2'b01, 64'hB000_0000_0000_0100, 16'h0001, "R4 call B1");
        issue(2'b01, 64'hB000_0000_0000_0200, 16'h0002, "R4 call B2");
        issue(2'b11, 64'hC000_0000_0000_0020, 16'h9999, "R7 R10 coro swap");
        issue(2'b11, 64'hC000_0000_0000_0030, 16'h0000, "R7 back to back swap");
        issue(2'b10, 64'h0, 16'h0, "R7 ret swapped");
        issue(2'b10, 64'h0, 16'h0, "R7 ret B1 depth kept");
        issue(2'b10, 64'h0, 16'h0, "R6 drained");
        for (int i = 1; i <= DEPTH + 2; i++) begin
            issue(2'b01, 64'hD000_0000_0000_0000 + 64'(i * 16), 16'(i), "R9 fill");
        end
        for (int i = 0; i < DEPTH + 1; i++) begin
            issue(2'b10, 64'h0, 16'h0, "R9 drain");
        end
        idle_chk("R2 tail");
        check(expq.size() == 0, "R2 all answered", 64'(expq.size()), '0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule